// File: doc/BRIEF.md
# Endpoint Fault Injection and Poison Control

This block sits between the memory access port of a PCIe-style endpoint model and the storage behind it. A 32-bit control word, written through a simple configuration port, chooses how traffic is treated. Corrupt-DMA mode tags every outgoing DMA as failing and attaches a configured 11-bit fault code. A one-shot injection request produces a single fault pulse that carries the same code. Poison mode isolates the memory: reads return all-ones, writes are dropped, and each poisoned access can raise a message toward the upstream port.

The poison message goes out only while the error-reporting enable input is high. Clearing the poison bit restores normal access from the next request. The block builds no packets and keeps no upstream status. It only produces strobes that the surrounding model turns into traffic.

Top module: `ep_fault_inject`

## Requirements
- R1: After reset the control word reads as zero, and no injection pulse, DMA failure flag or poison message is active.
- R2: The reserved bits of the control word always read as zero, whatever value was written. These are bit 31, bit 19 and bits 15:0.
- R3: Writing the control word with bit 17 set produces exactly one `injPulse`, high in the cycle after the write. During that pulse `injCode` equals bits 30:20 of the written word. Bit 17 reads back as zero from the following cycle onward.
- R4: While bit 16 (corrupt-DMA mode) is set, every valid DMA leaves with `dmaFail` high and `dmaErrCode` equal to the stored code. While bit 16 is clear, `dmaFail` is low and `dmaErrCode` is zero.
- R5: With poison mode clear, a BAR write stores its data and a BAR read returns the stored word. `barAck` rises in the cycle after each request.
- R6: While bit 18 (poison mode) is set, every BAR read returns all-ones.
- R7: While poison mode is set, BAR writes never reach the memory, so the stored contents stay unchanged.
- R8: Each BAR access made in poison mode gives exactly one `poisonMsg` pulse in the cycle after the request, but only if `rptEnable` was high with the request. Accesses made with poison mode clear give no pulse.
- R9: The first BAR access after a write that clears bit 18 behaves normally, both for reads and for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 32 | Control word write value |
| cfgRdData | output | 32 | Current control word |
| rptEnable | input | 1 | Error-reporting enable from the endpoint capability |
| barReq | input | 1 | BAR access request |
| barWe | input | 1 | 1 = write, 0 = read |
| barAddr | input | ADDR_W | BAR word address |
| barWdata | input | DATA_W | BAR write data |
| barRdata | output | DATA_W | BAR read data, valid with barAck |
| barAck | output | 1 | Access response, one cycle after barReq |
| memEn | output | 1 | Backing memory enable |
| memWe | output | 1 | Backing memory write enable |
| memAddr | output | ADDR_W | Backing memory address |
| memWdata | output | DATA_W | Backing memory write data |
| memRdata | input | DATA_W | Backing memory read data, one cycle latency |
| dmaValid | input | 1 | Outgoing DMA present |
| dmaFail | output | 1 | Outgoing DMA flagged as failing |
| dmaErrCode | output | 11 | Fault code attached to a failing DMA |
| injPulse | output | 1 | One-shot injection strobe |
| injCode | output | 11 | Fault code for the injection strobe |
| poisonMsg | output | 1 | Poison message pulse toward the upstream port |

## Verification
The bench targets the points where poison mode changes state. A design that latched the mode late would leak the first write after poison is set, or would still return all-ones on the first read after it is cleared. A write is made in poison mode and the same address is read back once the mode is off. This exposes a memory that was quietly updated. Poison messages are counted over whole runs of accesses and idle cycles. A design that pulsed on every cycle of the mode, or ignored the reporting enable, gets a wrong count. The injection bit is watched for a second pulse and for a sticky readback, and the reserved bits are written with ones.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int CFG_W      = 32;
  localparam int CODE_W     = 11;
  localparam int BIT_DMA    = 16;
  localparam int BIT_INJ    = 17;
  localparam int BIT_POISON = 18;
  localparam int CODE_LSB   = 20;
  localparam int CODE_MSB   = CODE_LSB + CODE_W - 1;

  typedef struct packed {
    logic              dmaCorrupt;
    logic              poison;
    logic              injFire;
    logic [CODE_W-1:0] code;
  } fiStrobe_t;
endpackage

// File: rtl/fi_ctrl.sv
module fi_ctrl
  import fi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  output fiStrobe_t        strb
);
  logic              dmaMode;
  logic              poisonMode;
  logic              injPending;
  logic [CODE_W-1:0] codeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaMode    <= 1'b0;
      poisonMode <= 1'b0;
      injPending <= 1'b0;
      codeReg    <= '0;
    end else begin
      // one-shot: set by the write, dropped on the next edge
      injPending <= cfgWrEn & cfgWrData[BIT_INJ];
      if (cfgWrEn) begin
        dmaMode    <= cfgWrData[BIT_DMA];
        poisonMode <= cfgWrData[BIT_POISON];
        codeReg    <= cfgWrData[CODE_MSB:CODE_LSB];
      end
    end
  end

  always_comb begin
    cfgRdData                    = '0;
    cfgRdData[BIT_DMA]           = dmaMode;
    cfgRdData[BIT_INJ]           = injPending;
    cfgRdData[BIT_POISON]        = poisonMode;
    cfgRdData[CODE_MSB:CODE_LSB] = codeReg;
  end

  always_comb begin
    strb.dmaCorrupt = dmaMode;
    strb.poison     = poisonMode;
    strb.injFire    = injPending;
    strb.code       = codeReg;
  end
endmodule

// File: rtl/fi_datapath.sv
module fi_datapath
  import fi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  fiStrobe_t         strb,
  input  logic              rptEnable,
  input  logic              barReq,
  input  logic              barWe,
  input  logic [ADDR_W-1:0] barAddr,
  input  logic [DATA_W-1:0] barWdata,
  output logic [DATA_W-1:0] barRdata,
  output logic              barAck,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              dmaValid,
  output logic              dmaFail,
  output logic [CODE_W-1:0] dmaErrCode,
  output logic              injPulse,
  output logic [CODE_W-1:0] injCode,
  output logic              poisonMsg
);
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  logic ackQ;
  logic poisonRespQ;
  logic msgQ;
  logic poisonHit;

  assign poisonHit = barReq & strb.poison;

  // memory is fenced off entirely while poisoned
  assign memEn    = barReq & ~strb.poison;
  assign memWe    = barReq & barWe & ~strb.poison;
  assign memAddr  = barAddr;
  assign memWdata = barWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackQ        <= 1'b0;
      poisonRespQ <= 1'b0;
      msgQ        <= 1'b0;
    end else begin
      ackQ        <= barReq;
      poisonRespQ <= poisonHit;
      msgQ        <= poisonHit & rptEnable;
    end
  end

  always_comb begin
    if (!ackQ)            barRdata = '0;
    else if (poisonRespQ) barRdata = ALL_ONES;
    else                  barRdata = memRdata;
  end

  assign barAck     = ackQ;
  assign poisonMsg  = msgQ;
  assign dmaFail    = dmaValid & strb.dmaCorrupt;
  assign dmaErrCode = dmaFail ? strb.code : '0;
  assign injPulse   = strb.injFire;
  assign injCode    = strb.injFire ? strb.code : '0;
endmodule

// File: rtl/ep_fault_inject.sv
module ep_fault_inject
  import fi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic              rptEnable,
  input  logic              barReq,
  input  logic              barWe,
  input  logic [ADDR_W-1:0] barAddr,
  input  logic [DATA_W-1:0] barWdata,
  output logic [DATA_W-1:0] barRdata,
  output logic              barAck,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              dmaValid,
  output logic              dmaFail,
  output logic [10:0]       dmaErrCode,
  output logic              injPulse,
  output logic [10:0]       injCode,
  output logic              poisonMsg
);
  fiStrobe_t strb;

  fi_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .strb      (strb)
  );

  fi_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rptEnable  (rptEnable),
    .barReq     (barReq),
    .barWe      (barWe),
    .barAddr    (barAddr),
    .barWdata   (barWdata),
    .barRdata   (barRdata),
    .barAck     (barAck),
    .memEn      (memEn),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .dmaValid   (dmaValid),
    .dmaFail    (dmaFail),
    .dmaErrCode (dmaErrCode),
    .injPulse   (injPulse),
    .injCode    (injCode),
    .poisonMsg  (poisonMsg)
  );
endmodule

// File: rtl/ep_fault_inject_chk.sv
module ep_fault_inject_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [31:0]       cfgWrData,
  input logic [31:0]       cfgRdData,
  input logic              rptEnable,
  input logic              barReq,
  input logic              barWe,
  input logic [DATA_W-1:0] barRdata,
  input logic              barAck,
  input logic              memWe,
  input logic              dmaValid,
  input logic              dmaFail,
  input logic              injPulse,
  input logic              poisonMsg
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData[31] == 1'b0) && (cfgRdData[19] == 1'b0) && (cfgRdData[15:0] == 16'h0));

  p_inj_from_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    injPulse |-> $past(cfgWrEn && cfgWrData[17]));

  p_dma_fail_mode_r4: assert property (@(posedge clk) disable iff (!rstN)
    dmaFail |-> (dmaValid && cfgRdData[16]));

  p_ack_follows_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    barReq |=> barAck);

  p_poison_ones_r6: assert property (@(posedge clk) disable iff (!rstN)
    (barReq && !barWe && cfgRdData[18]) |=> (barRdata == {DATA_W{1'b1}}));

  p_poison_no_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[18] |-> !memWe);

  p_msg_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    poisonMsg |-> $past(barReq && cfgRdData[18] && rptEnable));

  p_msg_when_enabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    (barReq && cfgRdData[18] && rptEnable) |=> poisonMsg);
endmodule

bind ep_fault_inject ep_fault_inject_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/ep_fault_inject_tb.sv
module ep_fault_inject_tb;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [31:0]   cfgWrData = '0;
  logic [31:0]   cfgRdData;
  logic          rptEnable = 1'b0;
  logic          barReq = 1'b0;
  logic          barWe = 1'b0;
  logic [AW-1:0] barAddr = '0;
  logic [DW-1:0] barWdata = '0;
  logic [DW-1:0] barRdata;
  logic          barAck;
  logic          memEn, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata;
  logic          dmaValid = 1'b0;
  logic          dmaFail;
  logic [10:0]   dmaErrCode;
  logic          injPulse;
  logic [10:0]   injCode;
  logic          poisonMsg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ep_fault_inject #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

  // backing memory model, one cycle read latency
  logic [DW-1:0] store [1<<AW];
  always_ff @(posedge clk) begin
    if (memEn) begin
      if (memWe) store[memAddr] <= memWdata;
      memRdata <= store[memAddr];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns at the falling edge after the write edge (injection pulse cycle)
  task automatic cfgWrite(input logic [31:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrData = '0;
  endtask

  // returns at the falling edge of the response cycle
  task automatic barAccess(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    barReq = 1'b1; barWe = we; barAddr = a; barWdata = d;
    @(negedge clk);
    barReq = 1'b0; barWe = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  kind;   // 0 cfg, 1 write, 2 read
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 4'd5, 8'h00, 32'h0000_0000},
    '{2'd1, 4'd5, 8'h10, 32'hA5A5_0001},
    '{2'd1, 4'd5, 8'h20, 32'h1234_5678},
    '{2'd2, 4'd5, 8'h10, 32'hA5A5_0001},
    '{2'd2, 4'd5, 8'h20, 32'h1234_5678},
    '{2'd0, 4'd6, 8'h00, 32'h0004_0000},
    '{2'd2, 4'd6, 8'h10, 32'hFFFF_FFFF},
    '{2'd1, 4'd7, 8'h10, 32'hDEAD_BEEF},
    '{2'd2, 4'd6, 8'h20, 32'hFFFF_FFFF},
    '{2'd0, 4'd9, 8'h00, 32'h0000_0000},
    '{2'd2, 4'd7, 8'h10, 32'hA5A5_0001},
    '{2'd1, 4'd9, 8'h10, 32'h0000_00C3},
    '{2'd2, 4'd9, 8'h10, 32'h0000_00C3}
  };

  function automatic string tagOf(input logic [3:0] r);
    case (r)
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R9";
    endcase
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int msgCount;
    int injCount;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(cfgRdData == 32'h0, "R1 cfg", cfgRdData, 32'h0);
    dmaValid = 1'b1;
    #0;
    check(!dmaFail && !injPulse && !poisonMsg && !barAck, "R1 outputs",
          {28'h0, dmaFail, injPulse, poisonMsg, barAck}, 32'h0);
    dmaValid = 1'b0;

    // vector table walk
    rptEnable = 1'b1;
    msgCount = 0;
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].kind == 2'd0) begin
        cfgWrite(TBL[i].data);
        if (poisonMsg) msgCount++;
      end else begin
        barAccess(TBL[i].kind == 2'd1, TBL[i].addr, TBL[i].data);
        check(barAck, {tagOf(TBL[i].req), " ack"}, {31'h0, barAck}, 32'h1);
        if (poisonMsg) msgCount++;
        if (TBL[i].kind == 2'd2)
          check(barRdata == TBL[i].data, {tagOf(TBL[i].req), " rdata"}, barRdata, TBL[i].data);
      end
      @(negedge clk);
      if (poisonMsg) msgCount++;
    end
    // three poisoned accesses with reporting on
    check(msgCount == 3, "R8 msg count", msgCount, 32'd3);

    // R2 reserved bits ignore writes
    cfgWrite(32'h8008_FFFF);
    @(negedge clk);
    check(cfgRdData == 32'h0, "R2 reserved", cfgRdData, 32'h0);

    // R3 one-shot injection with code 0x5A3
    injCount = 0;
    cfgWrite(32'h5A32_0000);
    check(injPulse && injCode == 11'h5A3, "R3 pulse",
          {20'h0, injPulse, injCode}, {20'h0, 1'b1, 11'h5A3});
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (injPulse) injCount++;
    end
    check(injCount == 0, "R3 single", injCount, 32'd0);
    check(cfgRdData == 32'h5A30_0000, "R3 readback", cfgRdData, 32'h5A30_0000);

    // R4 corrupt DMA with code 0x1F0
    cfgWrite(32'h1F01_0000);
    dmaValid = 1'b1;
    #1;
    check(dmaFail && dmaErrCode == 11'h1F0, "R4 fail",
          {20'h0, dmaFail, dmaErrCode}, {20'h0, 1'b1, 11'h1F0});
    dmaValid = 1'b0;
    #1;
    check(!dmaFail, "R4 idle", {31'h0, dmaFail}, 32'h0);
    cfgWrite(32'h1F00_0000);
    dmaValid = 1'b1;
    #1;
    check(!dmaFail && dmaErrCode == 11'h0, "R4 cleared",
          {20'h0, dmaFail, dmaErrCode}, 32'h0);
    dmaValid = 1'b0;

    // R8 reporting disabled: no message
    rptEnable = 1'b0;
    cfgWrite(32'h0004_0000);
    msgCount = 0;
    barAccess(1'b0, 8'h20, '0);
    if (poisonMsg) msgCount++;
    check(barRdata == 32'hFFFF_FFFF, "R6 rpt off", barRdata, 32'hFFFF_FFFF);
    repeat (3) begin @(negedge clk); if (poisonMsg) msgCount++; end
    check(msgCount == 0, "R8 gated", msgCount, 32'd0);

    // R8 back-to-back accesses give one pulse each, none while idle
    rptEnable = 1'b1;
    msgCount = 0;
    barReq = 1'b1; barWe = 1'b0; barAddr = 8'h10;
    @(negedge clk);
    if (poisonMsg) msgCount++;
    barWe = 1'b1; barWdata = 32'h0BAD_0BAD;
    @(negedge clk);
    if (poisonMsg) msgCount++;
    barReq = 1'b0; barWe = 1'b0;
    repeat (4) begin @(negedge clk); if (poisonMsg) msgCount++; end
    check(msgCount == 2, "R8 per access", msgCount, 32'd2);

    // R7/R9 clear poison, stored word is intact
    cfgWrite(32'h0);
    barAccess(1'b0, 8'h10, '0);
    check(barRdata == 32'h0000_00C3, "R7 intact", barRdata, 32'h0000_00C3);
    check(!poisonMsg, "R8 normal access", {31'h0, poisonMsg}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule